// File: doc/BRIEF.md
# Port Control Register Bank with Bit-Operation Aliases

This block is the register file behind a 16-bit general-purpose I/O port. It holds the port's level register and two independent interrupt-enable masks (called mask A and mask B), plus five per-pin configuration registers: direction, polarity, edge-select, both-edges and input-enable. Every register is exported in parallel so the neighbouring pin and interrupt logic can use it directly.

Each of the level register and the two masks has three extra write addresses. Writing to them clears, sets or toggles only the bits written as one, so software can change single pins without a read-modify-write sequence. Reading any of these extra addresses returns the register they belong to. The pin block can also push sampled input levels into the level register. Such a push is taken only on pins that are configured as inputs and have input sampling turned on.

The register bus is a plain single-cycle strobe interface without back-pressure: `wr_en` or `rd_en` is presented for one cycle with `addr`, and the access is always accepted. Read data and the error flag are registered and appear in the cycle after the strobe. The pin update port is likewise a per-bit strobe that is always accepted.

Top module: `gpio_regbank`

## Requirements
- R1: While `rst_n` is low and after it is released, every exported register, `rd_data` and `bus_err` are zero.
- R2: A write to a base address replaces the whole register. The byte offsets are: level 0x00, mask A 0x10, mask B 0x20, direction 0x30, polarity 0x34, edge-select 0x38, both-edges 0x3C, input-enable 0x40.
- R3: A write to base+0x04 of the level register or of either mask clears each bit where `wr_data` is 1 and leaves the other bits alone.
- R4: A write to base+0x08 of the level register or of either mask ORs `wr_data` into that register.
- R5: A write to base+0x0C of the level register or of either mask XORs `wr_data` into that register.
- R6: A read of any of the four addresses in a group (base, +0x04, +0x08, +0x0C) returns that group's register on `rd_data` in the cycle after `rd_en`. A read of the five configuration offsets returns the register itself.
- R7: An access is invalid when `addr[1:0]` is not zero or when the offset is above 0x40. An invalid access drives `bus_err` high for exactly the following cycle, changes no register, and reads back zero. `bus_err` is low after any cycle with no access.
- R8: In a cycle where `pin_upd[i]` is 1, level bit i takes `pin_lvl[i]` only if direction bit i is 0 (input) and input-enable bit i is 1. Otherwise the bit keeps its value.
- R9: When a bus write to the level group and a pin update occur in the same cycle, the bus operation is applied first. The eligible pin bits are then overwritten by `pin_lvl`.
- R10: The exported register outputs show the new value in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW (8) | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW (16) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW (16) | Read data, valid the cycle after `rd_en` |
| bus_err | output | 1 | Invalid-access flag, one cycle after the access |
| pin_upd | input | DW (16) | Per-pin update strobe from the pin block |
| pin_lvl | input | DW (16) | Sampled pin levels |
| level_q | output | DW (16) | Level register |
| mask_a_q | output | DW (16) | Interrupt mask A |
| mask_b_q | output | DW (16) | Interrupt mask B |
| dir_q | output | DW (16) | Direction (1 = output) |
| polar_q | output | DW (16) | Polarity |
| edge_q | output | DW (16) | Edge-select |
| both_q | output | DW (16) | Both-edges select |
| inen_q | output | DW (16) | Input enable |

## Verification
The hardest case to reach from the ports is a collision between a bus operation on the level group and a pin push in the same cycle. The outcome depends on the bus operation, on the direction and input-enable settings, and on which bits the pin block strobes. The bench first programs direction and input-enable through the bus to patterns that mix all four combinations across the pins. It then fires the bus write and the pin strobe on the same edge, cycling through all four operations of the level group. Exhaustive sweeps over all 256 byte offsets, for both writes and reads, cover the decode edges: misalignment, the end of the map, and the aliases.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;
  localparam int NUM_REGS    = 17;
  localparam int GRP_SPAN    = 4;
  localparam int NUM_ALIASED = 3;
  localparam int NUM_PLAIN   = NUM_REGS - NUM_ALIASED * GRP_SPAN;

  // index of each configuration register inside the plain array
  localparam int PL_DIR   = 0;
  localparam int PL_POLAR = 1;
  localparam int PL_EDGE  = 2;
  localparam int PL_BOTH  = 3;
  localparam int PL_INEN  = 4;

  // order is fixed by the address map: low two word-index bits pick it
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;
endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_rb_pkg::*;
#(
  parameter int AW   = 8,
  parameter int IDXW = 5
) (
  input  logic [AW-1:0]          addr,
  input  logic                   wr_en,
  output logic                   hit,
  output logic [IDXW-1:0]        idx,
  output alias_op_e              op,
  output logic [NUM_ALIASED-1:0] grp_we,
  output logic [NUM_PLAIN-1:0]   plain_we
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word;

  assign word = addr[AW-1:2];
  assign hit  = (addr[1:0] == 2'b00) && (word < WW'(NUM_REGS));
  assign idx  = word[IDXW-1:0];
  assign op   = alias_op_e'(idx[1:0]);

  for (genvar g = 0; g < NUM_ALIASED; g++) begin : g_grp
    assign grp_we[g] = wr_en && hit && (idx[IDXW-1:2] == (IDXW-2)'(g));
  end

  for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_plain
    assign plain_we[p] = wr_en && hit && (idx == IDXW'(NUM_ALIASED * GRP_SPAN + p));
  end
endmodule

// File: rtl/gpio_rb_aliasreg.sv
module gpio_rb_aliasreg
  import gpio_rb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  alias_op_e     op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_mask,
  input  logic [DW-1:0] pin_lvl,
  output logic [DW-1:0] q
);
  logic [DW-1:0] bus_nxt;
  logic [DW-1:0] nxt;

  always_comb begin
    bus_nxt = q;
    if (wr) begin
      unique case (op)
        OP_WRITE:  bus_nxt = wdata;
        OP_CLEAR:  bus_nxt = q & ~wdata;
        OP_SET:    bus_nxt = q | wdata;
        OP_TOGGLE: bus_nxt = q ^ wdata;
      endcase
    end
    // pin levels are merged after the bus operation
    nxt = (bus_nxt & ~pin_mask) | (pin_lvl & pin_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/gpio_rb_plainreg.sv
module gpio_rb_plainreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_rb_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          bus_err,
  input  logic [DW-1:0] pin_upd,
  input  logic [DW-1:0] pin_lvl,
  output logic [DW-1:0] level_q,
  output logic [DW-1:0] mask_a_q,
  output logic [DW-1:0] mask_b_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] polar_q,
  output logic [DW-1:0] edge_q,
  output logic [DW-1:0] both_q,
  output logic [DW-1:0] inen_q
);
  localparam int IDXW = $clog2(NUM_REGS);

  logic                   hit;
  logic [IDXW-1:0]        idx;
  alias_op_e              op;
  logic [NUM_ALIASED-1:0] grp_we;
  logic [NUM_PLAIN-1:0]   plain_we;
  logic [DW-1:0]          alias_q [NUM_ALIASED];
  logic [DW-1:0]          plain_q [NUM_PLAIN];
  logic [DW-1:0]          pin_take;
  logic [DW-1:0]          rd_mux;

  gpio_rb_decode #(.AW(AW), .IDXW(IDXW)) u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .hit      (hit),
    .idx      (idx),
    .op       (op),
    .grp_we   (grp_we),
    .plain_we (plain_we)
  );

  // pins accepted only where configured as enabled inputs
  assign pin_take = pin_upd & ~plain_q[PL_DIR] & plain_q[PL_INEN];

  for (genvar g = 0; g < NUM_ALIASED; g++) begin : g_alias
    gpio_rb_aliasreg #(.DW(DW)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (grp_we[g]),
      .op       (op),
      .wdata    (wr_data),
      .pin_mask ((g == 0) ? pin_take : '0),
      .pin_lvl  (pin_lvl),
      .q        (alias_q[g])
    );
  end

  for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_plain
    gpio_rb_plainreg #(.DW(DW)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (plain_we[p]),
      .wdata (wr_data),
      .q     (plain_q[p])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_ALIASED; g++) begin
      if (idx[IDXW-1:2] == (IDXW-2)'(g)) rd_mux = alias_q[g];
    end
    for (int p = 0; p < NUM_PLAIN; p++) begin
      if (idx == IDXW'(NUM_ALIASED * GRP_SPAN + p)) rd_mux = plain_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      bus_err <= 1'b0;
    end else begin
      rd_data <= (rd_en && hit) ? rd_mux : '0;
      bus_err <= (wr_en || rd_en) && !hit;
    end
  end

  assign level_q  = alias_q[0];
  assign mask_a_q = alias_q[1];
  assign mask_b_q = alias_q[2];
  assign dir_q    = plain_q[PL_DIR];
  assign polar_q  = plain_q[PL_POLAR];
  assign edge_q   = plain_q[PL_EDGE];
  assign both_q   = plain_q[PL_BOTH];
  assign inen_q   = plain_q[PL_INEN];
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic          bus_err,
  input logic [DW-1:0] pin_upd,
  input logic [DW-1:0] level_q,
  input logic [DW-1:0] mask_a_q,
  input logic [DW-1:0] mask_b_q,
  input logic [DW-1:0] dir_q,
  input logic [DW-1:0] inen_q
);
  AST_MISALIGNED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && (addr[1:0] != 2'b00) |=> bus_err); // R7
  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> !bus_err); // R7
  AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr[1:0] != 2'b00) && (pin_upd == '0) |=>
      $stable(level_q) && $stable(mask_a_q) && $stable(mask_b_q) && $stable(dir_q) && $stable(inen_q)); // R7
  AST_LEVEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == AW'(8'h04)) && (pin_upd == '0) |=> ((level_q & $past(wr_data)) == '0)); // R3
  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == AW'(8'h08)) && (pin_upd == '0) |=> ((level_q & $past(wr_data)) == $past(wr_data))); // R4
  AST_MASKA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == AW'(8'h18)) |=> ((mask_a_q & $past(wr_data)) == $past(wr_data))); // R4
  AST_LEVEL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == AW'(8'h0C)) && (pin_upd == '0) |=> (level_q == ($past(level_q) ^ $past(wr_data)))); // R5
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && (pin_upd != '0) |=>
      (((level_q ^ $past(level_q)) & ($past(dir_q) | ~$past(inen_q))) == '0)); // R8
endmodule

bind gpio_regbank gpio_regbank_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .bus_err  (bus_err),
  .pin_upd  (pin_upd),
  .level_q  (level_q),
  .mask_a_q (mask_a_q),
  .mask_b_q (mask_b_q),
  .dir_q    (dir_q),
  .inen_q   (inen_q)
);

// File: tb/gpio_regbank_test.sv
`timescale 1ns/1ps
module gpio_regbank_test;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          bus_err;
  logic [DW-1:0] pin_upd = '0;
  logic [DW-1:0] pin_lvl = '0;
  logic [DW-1:0] level_q, mask_a_q, mask_b_q, dir_q, polar_q, edge_q, both_q, inen_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model: 0 level, 1 maskA, 2 maskB, 3 dir, 4 polar, 5 edge, 6 both, 7 inen
  logic [DW-1:0] mdl [8];

  always #2 clk = ~clk;

  gpio_regbank #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .bus_err(bus_err),
    .pin_upd(pin_upd), .pin_lvl(pin_lvl),
    .level_q(level_q), .mask_a_q(mask_a_q), .mask_b_q(mask_b_q),
    .dir_q(dir_q), .polar_q(polar_q), .edge_q(edge_q), .both_q(both_q), .inen_q(inen_q)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit valid_addr(input int a);
    return (a % 4 == 0) && (a / 4 < 17);
  endfunction

  function automatic int reg_of(input int word);
    return (word < 12) ? word / 4 : word - 9;
  endfunction

  function automatic string tag_of(input int a);
    int w = a / 4;
    if (w >= 12 || w % 4 == 0) return "R2";
    if (w % 4 == 1) return "R3";
    if (w % 4 == 2) return "R4";
    return "R5";
  endfunction

  function automatic void model_write(input int a, input logic [DW-1:0] v);
    int w = a / 4;
    int r = reg_of(w);
    if (!valid_addr(a)) return;
    if (w >= 12) mdl[r] = v;
    else case (w % 4)
      0: mdl[r] = v;
      1: mdl[r] = mdl[r] & ~v;
      2: mdl[r] = mdl[r] | v;
      default: mdl[r] = mdl[r] ^ v;
    endcase
  endfunction

  function automatic void model_pins(input logic [DW-1:0] upd, input logic [DW-1:0] lvl);
    logic [DW-1:0] take = upd & ~mdl[3] & mdl[7];
    mdl[0] = (mdl[0] & ~take) | (lvl & take);
  endfunction

  task automatic check_outs(input string req);
    check(req, level_q, mdl[0]);
    check(req, mask_a_q, mdl[1]);
    check(req, mask_b_q, mdl[2]);
    check(req, dir_q, mdl[3]);
    check(req, polar_q, mdl[4]);
    check(req, edge_q, mdl[5]);
    check(req, both_q, mdl[6]);
    check(req, inen_q, mdl[7]);
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] v, output logic e);
    @(negedge clk);
    addr = AW'(a); wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    e = bus_err;
  endtask

  task automatic bus_read(input int a, output logic [DW-1:0] v, output logic e);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
    e = bus_err;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [DW-1:0] v;
    for (int i = 0; i < 8; i++) mdl[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check_outs("R1");
    check("R1", rd_data, '0);
    check("R1", {15'd0, bus_err}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1");

    // R2..R5, R7, R10: write sweep over every byte offset
    for (int a = 0; a < 256; a++) begin
      logic [DW-1:0] val = DW'(a * 40503 + 16'h3C5A);
      bus_write(a, val, e);
      model_write(a, val);
      if (valid_addr(a)) begin
        check("R7", {15'd0, e}, 16'd0);
        check_outs({tag_of(a), "/R10"});
      end else begin
        check("R7", {15'd0, e}, 16'd1);
        check_outs("R7");
      end
    end

    // R3..R5 corner values on mask B
    bus_write(8'h20, 16'hFFFF, e); model_write(8'h20, 16'hFFFF);
    bus_write(8'h24, 16'h0000, e); model_write(8'h24, 16'h0000);
    check("R3", mask_b_q, 16'hFFFF);
    bus_write(8'h2C, 16'hFFFF, e); model_write(8'h2C, 16'hFFFF);
    check("R5", mask_b_q, 16'h0000);
    bus_write(8'h28, 16'h8001, e); model_write(8'h28, 16'h8001);
    check("R4", mask_b_q, 16'h8001);

    // R6, R7: read sweep over every byte offset
    for (int a = 0; a < 256; a++) begin
      bus_read(a, v, e);
      if (valid_addr(a)) begin
        check("R6", v, mdl[reg_of(a / 4)]);
        check("R6", {15'd0, e}, 16'd0);
      end else begin
        check("R7", v, 16'd0);
        check("R7", {15'd0, e}, 16'd1);
      end
      @(negedge clk);
      check("R7", {15'd0, bus_err}, 16'd0);
    end

    // R8: pin pushes under varied direction / input-enable patterns
    for (int k = 0; k < 16; k++) begin
      logic [DW-1:0] dv = DW'(16'h5555 ^ (k * 16'h0F0F));
      logic [DW-1:0] iv = DW'(~(k * 16'h1111) ^ 16'h3333);
      bus_write(8'h30, dv, e); model_write(8'h30, dv);
      bus_write(8'h40, iv, e); model_write(8'h40, iv);
      bus_write(8'h00, DW'(k * 16'h2468), e); model_write(8'h00, DW'(k * 16'h2468));
      @(negedge clk);
      pin_upd = DW'(16'hFFFF >> (k % 4));
      pin_lvl = DW'(~(k * 16'h1357));
      @(negedge clk);
      model_pins(pin_upd, pin_lvl);
      pin_upd = '0;
      check("R8", level_q, mdl[0]);
    end

    // R9: bus write on the level group and pin push on the same edge
    for (int k = 0; k < 8; k++) begin
      logic [DW-1:0] wv = DW'(16'hA5F0 ^ (k * 16'h1111));
      bus_write(8'h30, 16'h00FF, e); model_write(8'h30, 16'h00FF);
      bus_write(8'h40, 16'h0FF0, e); model_write(8'h40, 16'h0FF0);
      @(negedge clk);
      addr = AW'((k % 4) * 4); wr_data = wv; wr_en = 1'b1;
      pin_upd = 16'hFFFF ^ DW'(k);
      pin_lvl = DW'(k * 16'h0F0F) ^ 16'hC3C3;
      model_write((k % 4) * 4, wv);
      model_pins(pin_upd, pin_lvl);
      @(negedge clk);
      wr_en = 1'b0; pin_upd = '0;
      check("R9", level_q, mdl[0]);
      bus_read((k % 4) * 4, v, e);
      check("R9", v, mdl[0]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule